// File: doc/BRIEF.md
# Multi-Range Sample Linearizer

This block sits at the back end of a front-end readout link. Each front-end channel delivers one compressed sample per 25 ns bunch crossing. A sample is a 12-bit mantissa plus a 2-bit range code. The range code tells which of three gain stages the front end selected. The stages differ in sensitivity: the most sensitive has 64 times the gain of the least sensitive, and the middle stage has 16 times. The block expands every sample into one 16-bit value on a common linear scale. It applies a multiplier and a signed offset chosen by channel and range code, and clamps the result to the unsigned 16-bit span.

The four channels arrive time-multiplexed on one sample port. Each sample carries its channel number and crossing number. The first sample of each crossing is marked with a start strobe. Calibration software rewrites constants through a write port at run time. Rewritten constants are staged in a shadow copy and become active only when the next crossing start is seen. As a result, all samples of one crossing use the same set of constants. A result leaves the block exactly two clocks after its sample enters, together with its tags.

Top module: `lin_range_linearizer`

## Requirements
- R1: While reset is asserted, `outValid` and `errFlag` read 0.
- R2: A sample accepted with `inValid` high appears two clocks later with `outValid` high, with the same `outChan` and `outBcid`. Idle input cycles produce `outValid` low two clocks later.
- R3: After reset, every channel uses multipliers of 64, 256 and 4096 for range codes 0, 1 and 2, with zero offsets. The result is `(mantissa * multiplier) >> 6 + offset`.
- R4: A result above 65535 is output as 65535.
- R5: A result below 0 is output as 0. The offset is an 18-bit two's-complement value.
- R6: A write with `cfgWrEn` high stores `cfgMult` and `cfgOfs` for the entry addressed by `cfgChan` and `cfgRange`.
- R7: A written constant first applies to the crossing whose start strobe (`inValid` and `inBcStart` both high) comes in a cycle after the write. Samples before that strobe, including a strobe in the same cycle as the write, use the previous constants.
- R8: A sample with range code 3 produces output 0 and sets `errFlag` two clocks after it enters.
- R9: `errFlag` stays set until a cycle with `errClr` high clears it. A new range-3 result arriving in the same cycle as a clear leaves the flag set.
- R10: The constants of each channel are independent. A write to one channel does not change the results of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Sample present this cycle |
| inBcStart | input | 1 | Marks the first sample of a crossing |
| inChan | input | 2 | Channel number of the sample |
| inBcid | input | BCID_W | Crossing number of the sample |
| inMant | input | 12 | Mantissa |
| inRange | input | 2 | Range code, 3 is invalid |
| cfgWrEn | input | 1 | Constant write strobe |
| cfgChan | input | 2 | Channel of the written entry |
| cfgRange | input | 2 | Range code of the written entry |
| cfgMult | input | 16 | Unsigned multiplier |
| cfgOfs | input | 18 | Two's-complement offset |
| errClr | input | 1 | Clears the error flag |
| outValid | output | 1 | Result present |
| outChan | output | 2 | Channel number of the result |
| outBcid | output | BCID_W | Crossing number of the result |
| outData | output | 16 | Linear result |
| errFlag | output | 1 | Sticky invalid-range flag |

## Verification
The hardest situation to reach is a constant write that lands in the middle of a crossing. Half of that crossing must still use the old entry and the next crossing must use the new one. A write in the very cycle of a start strobe is a second such case. The stimulus places writes on exact channel slots of a crossing, including the strobe slot. It then samples the written channel both before and after the next strobe. A long random phase mixes writes, strobes, idle cycles and range-3 samples. This phase also produces clears that coincide with fresh error results.

// File: rtl/lin_pkg.sv
package lin_pkg;
  localparam int MANT_W  = 12;
  localparam int RNG_W   = 2;
  localparam int CH_W    = 2;
  localparam int NUM_CH  = 1 << CH_W;
  localparam int NUM_RNG = 1 << RNG_W;
  localparam int MULT_W  = 16;
  localparam int OFS_W   = 18;
  localparam int OUT_W   = 16;
  localparam logic [RNG_W-1:0] BAD_RNG = RNG_W'(NUM_RNG - 1);

  typedef struct packed {
    logic [MULT_W-1:0]       mult;
    logic signed [OFS_W-1:0] ofs;
  } calEntry_t;

  typedef struct packed {
    logic             commit;
    logic             wrEn;
    logic [CH_W-1:0]  wrChan;
    logic [RNG_W-1:0] wrRng;
    calEntry_t        wrData;
    logic             errClr;
  } ctrlStrobes_t;

  // power-on constants: range 0 is the most sensitive stage
  function automatic calEntry_t defaultEntry(int rng);
    calEntry_t e;
    case (rng)
      0:       e.mult = MULT_W'(64);
      1:       e.mult = MULT_W'(256);
      2:       e.mult = MULT_W'(4096);
      default: e.mult = '0;
    endcase
    e.ofs = '0;
    return e;
  endfunction
endpackage

// File: rtl/lin_ctrl.sv
module lin_ctrl
  import lin_pkg::*;
(
  input  logic               inValid,
  input  logic               inBcStart,
  input  logic               cfgWrEn,
  input  logic [CH_W-1:0]    cfgChan,
  input  logic [RNG_W-1:0]   cfgRange,
  input  logic [MULT_W-1:0]  cfgMult,
  input  logic [OFS_W-1:0]   cfgOfs,
  input  logic               errClr,
  output ctrlStrobes_t       strobes
);
  always_comb begin
    strobes.commit      = inValid & inBcStart;
    strobes.wrEn        = cfgWrEn;
    strobes.wrChan      = cfgChan;
    strobes.wrRng       = cfgRange;
    strobes.wrData.mult = cfgMult;
    strobes.wrData.ofs  = $signed(cfgOfs);
    strobes.errClr      = errClr;
  end
endmodule

// File: rtl/lin_table.sv
module lin_table
  import lin_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [CH_W-1:0]  rdChan,
  input  logic [RNG_W-1:0] rdRng,
  output calEntry_t        rdEntry
);
  calEntry_t shadowTab [NUM_CH][NUM_RNG];
  calEntry_t activeTab [NUM_CH][NUM_RNG];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    for (genvar rg = 0; rg < NUM_RNG; rg++) begin : g_rng
      logic hit;
      assign hit = strobes.wrEn && (strobes.wrChan == CH_W'(ch)) && (strobes.wrRng == RNG_W'(rg));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          shadowTab[ch][rg] <= defaultEntry(rg);
          activeTab[ch][rg] <= defaultEntry(rg);
        end else begin
          if (hit)            shadowTab[ch][rg] <= strobes.wrData;
          if (strobes.commit) activeTab[ch][rg] <= shadowTab[ch][rg];
        end
      end
    end
  end

  // the sample carrying the crossing start already sees the staged set
  assign rdEntry = strobes.commit ? shadowTab[rdChan][rdRng] : activeTab[rdChan][rdRng];
endmodule

// File: rtl/lin_datapath.sv
module lin_datapath
  import lin_pkg::*;
#(
  parameter int BCID_W = 12,
  parameter int SHIFT  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              inValid,
  input  logic [CH_W-1:0]   inChan,
  input  logic [BCID_W-1:0] inBcid,
  input  logic [MANT_W-1:0] inMant,
  input  logic [RNG_W-1:0]  inRange,
  input  calEntry_t         calIn,
  output logic              outValid,
  output logic [CH_W-1:0]   outChan,
  output logic [BCID_W-1:0] outBcid,
  output logic [OUT_W-1:0]  outData,
  output logic              errFlag
);
  localparam int PROD_W = MANT_W + MULT_W;
  localparam int SH_W   = PROD_W - SHIFT;
  localparam int SUM_W  = SH_W + 2;

  logic              s1Valid;
  logic [CH_W-1:0]   s1Chan;
  logic [BCID_W-1:0] s1Bcid;
  logic [MANT_W-1:0] s1Mant;
  logic [RNG_W-1:0]  s1Rng;
  calEntry_t         s1Cal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Chan  <= '0;
      s1Bcid  <= '0;
      s1Mant  <= '0;
      s1Rng   <= '0;
      s1Cal   <= '0;
    end else begin
      s1Valid <= inValid;
      s1Chan  <= inChan;
      s1Bcid  <= inBcid;
      s1Mant  <= inMant;
      s1Rng   <= inRange;
      s1Cal   <= calIn;
    end
  end

  logic [PROD_W-1:0]       prod;
  logic [SH_W-1:0]         scaled;
  logic signed [SUM_W-1:0] ofsExt;
  logic signed [SUM_W-1:0] sum;
  logic                    s1Bad;
  logic [OUT_W-1:0]        linVal;

  always_comb begin
    prod   = PROD_W'(s1Mant) * PROD_W'(s1Cal.mult);
    scaled = prod[PROD_W-1:SHIFT];
    ofsExt = {{(SUM_W-OFS_W){s1Cal.ofs[OFS_W-1]}}, s1Cal.ofs};
    sum    = $signed({2'b00, scaled}) + ofsExt;
    s1Bad  = (s1Rng == BAD_RNG);
    if (s1Bad || sum[SUM_W-1])       linVal = '0;
    else if (|sum[SUM_W-2:OUT_W])    linVal = '1;
    else                             linVal = sum[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outChan  <= '0;
      outBcid  <= '0;
      outData  <= '0;
      errFlag  <= 1'b0;
    end else begin
      outValid <= s1Valid;
      outChan  <= s1Chan;
      outBcid  <= s1Bcid;
      outData  <= linVal;
      if (s1Valid && s1Bad)    errFlag <= 1'b1;
      else if (strobes.errClr) errFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/lin_range_linearizer.sv
module lin_range_linearizer
  import lin_pkg::*;
#(
  parameter int BCID_W = 12,
  parameter int SHIFT  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inBcStart,
  input  logic [CH_W-1:0]   inChan,
  input  logic [BCID_W-1:0] inBcid,
  input  logic [MANT_W-1:0] inMant,
  input  logic [RNG_W-1:0]  inRange,
  input  logic              cfgWrEn,
  input  logic [CH_W-1:0]   cfgChan,
  input  logic [RNG_W-1:0]  cfgRange,
  input  logic [MULT_W-1:0] cfgMult,
  input  logic [OFS_W-1:0]  cfgOfs,
  input  logic              errClr,
  output logic              outValid,
  output logic [CH_W-1:0]   outChan,
  output logic [BCID_W-1:0] outBcid,
  output logic [OUT_W-1:0]  outData,
  output logic              errFlag
);
  ctrlStrobes_t strobes;
  calEntry_t    calEntry;

  lin_ctrl u_ctrl (
    .inValid   (inValid),
    .inBcStart (inBcStart),
    .cfgWrEn   (cfgWrEn),
    .cfgChan   (cfgChan),
    .cfgRange  (cfgRange),
    .cfgMult   (cfgMult),
    .cfgOfs    (cfgOfs),
    .errClr    (errClr),
    .strobes   (strobes)
  );

  lin_table u_table (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rdChan  (inChan),
    .rdRng   (inRange),
    .rdEntry (calEntry)
  );

  lin_datapath #(.BCID_W(BCID_W), .SHIFT(SHIFT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inValid  (inValid),
    .inChan   (inChan),
    .inBcid   (inBcid),
    .inMant   (inMant),
    .inRange  (inRange),
    .calIn    (calEntry),
    .outValid (outValid),
    .outChan  (outChan),
    .outBcid  (outBcid),
    .outData  (outData),
    .errFlag  (errFlag)
  );
endmodule

// File: rtl/lin_range_linearizer_chk.sv
module lin_range_linearizer_chk
  import lin_pkg::*;
#(
  parameter int BCID_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [CH_W-1:0]   inChan,
  input logic [BCID_W-1:0] inBcid,
  input logic [RNG_W-1:0]  inRange,
  input logic              errClr,
  input logic              outValid,
  input logic [CH_W-1:0]   outChan,
  input logic [BCID_W-1:0] outBcid,
  input logic [OUT_W-1:0]  outData,
  input logic              errFlag
);
  logic [1:0] edgesUp;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                edgesUp <= '0;
    else if (edgesUp != 2'd3) edgesUp <= edgesUp + 2'd1;
  end

  assert_reset_R1: assert property (@(posedge clk)
    !rstN |-> (!outValid && !errFlag));

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (edgesUp >= 2'd2) |-> (outValid == $past(inValid, 2)) &&
      (!outValid || (outChan == $past(inChan, 2) && outBcid == $past(inBcid, 2))));

  assert_bad_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (edgesUp >= 2'd2 && $past(inValid, 2) && $past(inRange, 2) == BAD_RNG)
      |-> (outData == '0 && errFlag));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (edgesUp >= 2'd1 && $past(errFlag) && !$past(errClr)) |-> errFlag);
endmodule

bind lin_range_linearizer lin_range_linearizer_chk #(.BCID_W(BCID_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inChan   (inChan),
  .inBcid   (inBcid),
  .inRange  (inRange),
  .errClr   (errClr),
  .outValid (outValid),
  .outChan  (outChan),
  .outBcid  (outBcid),
  .outData  (outData),
  .errFlag  (errFlag)
);

// File: tb/lin_range_linearizer_tb.sv
`timescale 1ns/1ps
module lin_range_linearizer_tb;
  localparam int BCID_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic inValid = 1'b0, inBcStart = 1'b0;
  logic [1:0] inChan = '0, inRange = '0;
  logic [BCID_W-1:0] inBcid = '0;
  logic [11:0] inMant = '0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgChan = '0, cfgRange = '0;
  logic [15:0] cfgMult = '0;
  logic [17:0] cfgOfs = '0;
  logic errClr = 1'b0;
  logic outValid, errFlag;
  logic [1:0] outChan;
  logic [BCID_W-1:0] outBcid;
  logic [15:0] outData;

  always #2.5 clk = ~clk;

  lin_range_linearizer #(.BCID_W(BCID_W)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBcStart(inBcStart),
    .inChan(inChan), .inBcid(inBcid), .inMant(inMant), .inRange(inRange),
    .cfgWrEn(cfgWrEn), .cfgChan(cfgChan), .cfgRange(cfgRange),
    .cfgMult(cfgMult), .cfgOfs(cfgOfs), .errClr(errClr),
    .outValid(outValid), .outChan(outChan), .outBcid(outBcid),
    .outData(outData), .errFlag(errFlag)
  );

  int nChk = 0, nFail = 0;
  string tag = "R1";

  // reference model state
  int shMult[4][4], shOfs[4][4], acMult[4][4], acOfs[4][4];
  int e1v, e1ch, e1bc, e1d, e2v, e2ch, e2bc, e2d;
  int expErr, prevBad;

  // drive variables for the next tick
  int dV, dBc, dCh, dBcid, dMant, dRng, dWr, dWch, dWrg, dMult, dOfs, dClr;

  task automatic check(string rq, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int refLin(int mant, int mult, int ofs);
    int s;
    s = ((mant * mult) >> 6) + ofs;
    if (s < 0) s = 0;          // R5
    if (s > 65535) s = 65535;  // R4
    return s;
  endfunction

  task automatic tick();
    int nd, bad;
    @(negedge clk);
    check(tag, "outValid", int'(outValid), e2v);         // R2
    if (e2v != 0) begin
      check(tag, "outChan", int'(outChan), e2ch);
      check(tag, "outBcid", int'(outBcid), e2bc);
      check(tag, "outData", int'(outData), e2d);
    end
    check(tag, "errFlag", int'(errFlag), expErr);
    inValid = dV[0]; inBcStart = dBc[0]; inChan = dCh[1:0];
    inBcid = dBcid[BCID_W-1:0]; inMant = dMant[11:0]; inRange = dRng[1:0];
    cfgWrEn = dWr[0]; cfgChan = dWch[1:0]; cfgRange = dWrg[1:0];
    cfgMult = dMult[15:0]; cfgOfs = dOfs[17:0]; errClr = dClr[0];
    if (dV != 0 && dBc != 0) begin                       // R7 commit
      acMult = shMult; acOfs = shOfs;
    end
    bad = (dV != 0 && dRng == 3) ? 1 : 0;
    nd = (dRng == 3) ? 0 : refLin(dMant, acMult[dCh][dRng], acOfs[dCh][dRng]);
    expErr = (prevBad != 0) ? 1 : ((dClr != 0) ? 0 : expErr);  // R9
    prevBad = bad;
    e2v = e1v; e2ch = e1ch; e2bc = e1bc; e2d = e1d;
    e1v = dV; e1ch = dCh; e1bc = dBcid; e1d = nd;
    if (dWr != 0) begin
      shMult[dWch][dWrg] = dMult; shOfs[dWch][dWrg] = dOfs;
    end
    dWr = 0; dClr = 0; dBc = 0;
  endtask

  task automatic sample(int bc, int ch, int bcid, int mant, int rng);
    dV = 1; dBc = bc; dCh = ch; dBcid = bcid; dMant = mant; dRng = rng;
    tick();
    dV = 0;
  endtask

  task automatic setWrite(int ch, int rg, int mult, int ofs);
    dWr = 1; dWch = ch; dWrg = rg; dMult = mult; dOfs = ofs;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    dV = 0; dBc = 0; dCh = 0; dBcid = 0; dMant = 0; dRng = 0;
    dWr = 0; dWch = 0; dWrg = 0; dMult = 0; dOfs = 0; dClr = 0;
    for (int c = 0; c < 4; c++) begin
      shMult[c][0] = 64; shMult[c][1] = 256; shMult[c][2] = 4096; shMult[c][3] = 0;
      for (int r = 0; r < 4; r++) shOfs[c][r] = 0;
    end
    acMult = shMult; acOfs = shOfs;
    e1v = 0; e2v = 0; e1ch = 0; e2ch = 0; e1bc = 0; e2bc = 0; e1d = 0; e2d = 0;
    expErr = 0; prevBad = 0;

    // R1: reset state
    #1 rstN = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1", "outValid", int'(outValid), 0);
      check("R1", "errFlag", int'(errFlag), 0);
    end
    rstN = 1'b1;

    // R2 R3 R4: default constants, all channels, several patterns
    tag = "R3";
    for (int b = 0; b < 16; b++)
      for (int c = 0; c < 4; c++)
        sample(c == 0, c, b, (b * 37 + c * 511) % 4096, (b + c) % 3);
    tag = "R4";
    for (int r = 0; r < 3; r++) sample(r == 0, r, 16, 4095, r);
    sample(1, 0, 17, 1024, 2);   // 65536 clamps to 65535
    sample(0, 1, 17, 1023, 2);   // 65472 stays
    tag = "R2";
    for (int i = 0; i < 3; i++) tick();   // idle cycles

    // R6 R7 R10: write in mid-crossing and in the strobe cycle
    tag = "R7";
    setWrite(1, 0, 100, -300);
    sample(1, 0, 20, 1000, 0);
    sample(0, 1, 20, 1000, 0);   // still old constants
    sample(1, 1, 21, 1000, 0);   // new: 1562-300
    tag = "R10";
    sample(0, 0, 21, 1000, 0);   // other channel unchanged
    tag = "R7";
    setWrite(1, 0, 64, 5);
    sample(1, 1, 22, 1000, 0);   // write in strobe cycle: old still used
    sample(1, 1, 23, 1000, 0);   // now +5
    tag = "R6";
    setWrite(3, 2, 1, 7);
    tick();
    sample(1, 3, 24, 4095, 2);

    // R5: negative clamp, and R4 via positive offset
    tag = "R5";
    setWrite(2, 1, 256, -100000);
    tick();
    sample(1, 2, 25, 10, 1);
    sample(0, 2, 25, 4095, 1);
    tag = "R4";
    setWrite(3, 0, 64, 70000);
    tick();
    sample(1, 3, 26, 1, 0);

    // R8 R9: invalid range, sticky flag, clear, coincident set and clear
    tag = "R8";
    sample(1, 0, 27, 1234, 3);
    for (int i = 0; i < 4; i++) tick();
    tag = "R9";
    dClr = 1; tick();
    tick(); tick();
    sample(1, 1, 28, 55, 3);
    dClr = 1; tick();            // clear meets the new set
    tick(); tick();
    dClr = 1; tick();
    tick();

    // mixed random traffic
    tag = "R3/R7/R9";
    begin
      int bcid = 30, ch = 0;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(0, 9) < 8) begin
          dV = 1; dBc = (ch == 0) ? 1 : 0; dCh = ch; dBcid = bcid;
          dMant = $urandom_range(0, 4095);
          dRng = ($urandom_range(0, 15) == 0) ? 3 : $urandom_range(0, 2);
          ch = (ch + 1) % 4;
          if (ch == 0) bcid = (bcid + 1) % 4096;
        end else begin
          dV = 0;
        end
        if ($urandom_range(0, 7) == 0)
          setWrite($urandom_range(0, 3), $urandom_range(0, 3),
                   $urandom_range(0, 65535), $urandom_range(0, 262143) - 131072);
        if ($urandom_range(0, 11) == 0) dClr = 1;
        tick();
        dV = 0;
      end
    end
    for (int i = 0; i < 3; i++) tick();
    finishRun();
  end
endmodule